// File: doc/BRIEF.md
# RS-485 Transceiver Direction Controller

This block sits next to a 16550-style UART and steers an external RS-422/RS-485 line transceiver. Software picks one of four wire modes through a byte-wide control register. The block then decides, every clock, whether the line driver is on and whether the receiver is listening. Its inputs are the UART's DTR output, a flag that says the transmit FIFO holds data and a flag that says the transmit shift register is still sending. A further control bit switches the bus termination, and a master enable bit turns the whole transceiver off.

The same register port exposes read-only bytes that describe the port: the transmit and receive FIFO depths, the port capability and the interface currently in use. These values come from parameters, so the UART driver can discover the port without needing board-specific knowledge. Driver-enable and receiver-enable are registered outputs. In automatic mode the driver stays on until the shift register has sent the final stop bit, so the last character on the line is complete.

Top module: `xcvr_dir_ctrl`

## Requirements
- R1: After reset the control register (offset 0x0F) reads 0x03: wire mode field bits [1:0] = 3 (automatic), master enable bit 3 = 0, termination bit 6 = 0. Driver-enable, receiver-enable and termination outputs are 0.
- R2: With wire mode 0 (full-duplex RS-422) and the enable bit set, driver-enable and receiver-enable are both 1 regardless of DTR and the transmit flags.
- R3: With wire mode 1 (echo RS-485) and the enable bit set, driver-enable equals DTR and receiver-enable is 1.
- R4: With wire mode 2 (DTR-keyed RS-485) and the enable bit set, driver-enable equals DTR and receiver-enable is the inverse of driver-enable.
- R5: With wire mode 3 (automatic RS-485) and the enable bit set, driver-enable is 1 while the TX-FIFO-not-empty flag or the shift-busy flag is 1, so it drops only after the shift register goes idle; receiver-enable is the inverse of driver-enable.
- R6: When control bit 3 is 0, driver-enable and receiver-enable are both 0 in every wire mode.
- R7: The termination output follows control bit 6, taking the written value at the clock edge of the write.
- R8: Offset 0x0E reads capability code CAP in bits [1:0] (0 none, 1 RS-232 only, 2 RS-485 only, 3 dual) and the current interface in bit 4 (1 = RS-485); other bits read 0. Defaults give 0x13.
- R9: Offsets 0x0C and 0x0D read the TX and RX FIFO depths (values above 255 read 255), 128 by default; writes to them have no effect.
- R10: Driver-enable and receiver-enable are registered: they show a change in their inputs one clock edge later. They are never both 1 in an edge that follows a cycle in mode 2 or 3.
- R11: Only control bits 0, 1, 3 and 6 are stored; the other bits read 0. Offsets other than 0x0C to 0x0F read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| uart_dtr | input | 1 | DTR from the UART, 1 = asserted |
| txf_nempty | input | 1 | Transmit FIFO holds data |
| tsr_busy | input | 1 | Transmit shift register is sending |
| drv_en | output | 1 | Line driver enable |
| rcv_en | output | 1 | Receiver enable |
| term_en | output | 1 | Bus termination enable |

## Verification
A control-register write and a change on the UART status flags can both reach the direction registers in the same cycle. The bench provokes this by writing a new wire mode and moving DTR and the transmit flags on the same falling edge. It then judges the outputs two edges later against a table that recomputes the expected driver and receiver state from the new mode alone. A separate case in automatic mode lets the FIFO empty while the shift register stays busy. The driver must hold until the busy flag falls, and the receiver must come back on the following edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    WM_FULL422 = 2'd0,
    WM_ECHO485 = 2'd1,
    WM_DTR485  = 2'd2,
    WM_AUTO485 = 2'd3
  } wire_mode_e;

  localparam logic [3:0] OFS_TXDEPTH = 4'hC;
  localparam logic [3:0] OFS_RXDEPTH = 4'hD;
  localparam logic [3:0] OFS_PORTID  = 4'hE;
  localparam logic [3:0] OFS_CTRL    = 4'hF;

  localparam int CTL_EN_BIT   = 3;
  localparam int CTL_TERM_BIT = 6;
  localparam logic [7:0] CTL_KEEP  = 8'h4B;
  localparam logic [7:0] CTL_RESET = 8'h03;

  // Line driver wanted for a given mode and status
  function automatic logic want_drive(wire_mode_e m, logic dtr, logic pend);
    case (m)
      WM_FULL422: want_drive = 1'b1;
      WM_ECHO485,
      WM_DTR485:  want_drive = dtr;
      default:    want_drive = pend;
    endcase
  endfunction

  // Receiver wanted given the mode and the driver decision
  function automatic logic want_recv(wire_mode_e m, logic drv);
    want_recv = (m == WM_FULL422 || m == WM_ECHO485) ? 1'b1 : !drv;
  endfunction

  function automatic logic half_duplex(wire_mode_e m);
    half_duplex = (m == WM_DTR485 || m == WM_AUTO485);
  endfunction

  // Depth byte, clipped at 255
  function automatic logic [7:0] depth_byte(int d);
    depth_byte = (d > 255) ? 8'hFF : d[7:0];
  endfunction

endpackage

// File: rtl/xcvr_ctl_regs.sv
module xcvr_ctl_regs
  import xcvr_pkg::*;
#(
  parameter int TX_DEPTH  = 128,
  parameter int RX_DEPTH  = 128,
  parameter int CAP_CODE  = 3,
  parameter bit IFACE_485 = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] addr,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output wire_mode_e mode,
  output logic       xcvr_on,
  output logic       term
);

  localparam logic [7:0] TXD_BYTE = depth_byte(TX_DEPTH);
  localparam logic [7:0] RXD_BYTE = depth_byte(RX_DEPTH);
  localparam logic [1:0] CAP_BITS = CAP_CODE[1:0];
  localparam logic [7:0] ID_BYTE  = {3'b000, IFACE_485, 2'b00, CAP_BITS};

  logic [7:0] ctl_q;
  logic       ctl_wr;

  assign ctl_wr = wr && (addr == OFS_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else if (ctl_wr) ctl_q <= wdata & CTL_KEEP;
  end

  assign mode    = wire_mode_e'(ctl_q[1:0]);
  assign xcvr_on = ctl_q[CTL_EN_BIT];
  assign term    = ctl_q[CTL_TERM_BIT];

  always_comb begin
    case (addr)
      OFS_TXDEPTH: rdata = TXD_BYTE;
      OFS_RXDEPTH: rdata = RXD_BYTE;
      OFS_PORTID:  rdata = ID_BYTE;
      OFS_CTRL:    rdata = ctl_q;
      default:     rdata = 8'h00;
    endcase
  end

  // R11
  ctl_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ((ctl_q & ~CTL_KEEP) == 8'h00));

  // R7
  term_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (term == $past(wdata[CTL_TERM_BIT])));

endmodule

// File: rtl/xcvr_dir_logic.sv
module xcvr_dir_logic
  import xcvr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  wire_mode_e mode,
  input  logic       xcvr_on,
  input  logic       dtr,
  input  logic       fifo_pend,
  input  logic       shift_busy,
  output logic       drv_q,
  output logic       rcv_q
);

  logic tx_pending;
  logic drv_next;
  logic rcv_next;
  logic hd_q;

  // pending covers the final stop bit in the shift register
  assign tx_pending = fifo_pend || shift_busy;
  assign drv_next   = xcvr_on && want_drive(mode, dtr, tx_pending);
  assign rcv_next   = xcvr_on && want_recv(mode, want_drive(mode, dtr, tx_pending));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_q <= 1'b0;
      rcv_q <= 1'b0;
      hd_q  <= 1'b1;
    end else begin
      drv_q <= drv_next;
      rcv_q <= rcv_next;
      hd_q  <= half_duplex(mode);
    end
  end

  // R10
  hd_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hd_q |-> !(drv_q && rcv_q));

  // R6
  master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xcvr_on |=> (!drv_q && !rcv_q));

  // R5
  auto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xcvr_on && mode == WM_AUTO485 && (fifo_pend || shift_busy)) |=> (drv_q && !rcv_q));

  // R2
  full_duplex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xcvr_on && mode == WM_FULL422) |=> (drv_q && rcv_q));

  // R3
  echo_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xcvr_on && mode == WM_ECHO485) |=> (rcv_q && drv_q == $past(dtr)));

endmodule

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
  import xcvr_pkg::*;
#(
  parameter int TX_DEPTH  = 128,
  parameter int RX_DEPTH  = 128,
  parameter int CAP_CODE  = 3,
  parameter bit IFACE_485 = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       uart_dtr,
  input  logic       txf_nempty,
  input  logic       tsr_busy,
  output logic       drv_en,
  output logic       rcv_en,
  output logic       term_en
);

  wire_mode_e mode_w;
  logic       on_w;

  xcvr_ctl_regs #(
    .TX_DEPTH (TX_DEPTH),
    .RX_DEPTH (RX_DEPTH),
    .CAP_CODE (CAP_CODE),
    .IFACE_485(IFACE_485)
  ) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (reg_addr),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .mode   (mode_w),
    .xcvr_on(on_w),
    .term   (term_en)
  );

  xcvr_dir_logic dir_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_w),
    .xcvr_on   (on_w),
    .dtr       (uart_dtr),
    .fifo_pend (txf_nempty),
    .shift_busy(tsr_busy),
    .drv_q     (drv_en),
    .rcv_q     (rcv_en)
  );

endmodule

// File: tb/xcvr_dir_ctrl_tb.sv
module xcvr_dir_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       uart_dtr = 1'b0;
  logic       txf_nempty = 1'b0;
  logic       tsr_busy = 1'b0;
  logic       drv_en, rcv_en, term_en;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xcvr_dir_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .uart_dtr(uart_dtr), .txf_nempty(txf_nempty), .tsr_busy(tsr_busy),
    .drv_en(drv_en), .rcv_en(rcv_en), .term_en(term_en)
  );

  // {mode[1:0], enable, dtr, fifo, busy, exp_drv, exp_rcv}
  localparam logic [7:0] VEC [12] = '{
    8'h23, 8'h61, 8'h73, 8'hB2, 8'hA1, 8'hEA,
    8'hE6, 8'hF1, 8'h00, 8'h90, 8'hC8, 8'h7B
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
    reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  function automatic string tag_for(logic [1:0] m, logic en);
    if (!en) return "R6";
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog: got 0x00 expected 0x01");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd_check("R1", 4'hF, 8'h03);
    check("R1", {5'b0, drv_en, rcv_en, term_en}, 8'h00);
    // R8, R9 identity bytes
    rd_check("R8", 4'hE, 8'h13);
    rd_check("R9", 4'hC, 8'd128);
    rd_check("R9", 4'hD, 8'd128);
    wr_reg(4'hC, 8'h55);
    rd_check("R9", 4'hC, 8'd128);
    wr_reg(4'hD, 8'h00);
    rd_check("R9", 4'hD, 8'd128);
    // R11 unmapped offset and masked bits
    rd_check("R11", 4'h3, 8'h00);
    wr_reg(4'hF, 8'hFF);
    rd_check("R11", 4'hF, 8'h4B);

    // table walk: mode write and status change in the same cycle
    foreach (VEC[i]) begin
      logic [7:0] v;
      v = VEC[i];
      uart_dtr = v[4]; txf_nempty = v[3]; tsr_busy = v[2];
      wr_reg(4'hF, {4'b0000, v[5], 1'b0, v[7:6]});
      @(posedge clk); @(negedge clk);
      check(tag_for(v[7:6], v[5]), {6'b0, drv_en, rcv_en}, {6'b0, v[1:0]});
    end

    // R7 termination follows bit 6
    uart_dtr = 1'b0; txf_nempty = 1'b0; tsr_busy = 1'b0;
    wr_reg(4'hF, 8'h4B);
    check("R7", {7'b0, term_en}, 8'h01);
    rd_check("R11", 4'hF, 8'h4B);
    wr_reg(4'hF, 8'h0B);
    check("R7", {7'b0, term_en}, 8'h00);

    // R10 one-edge latency, R5 tail until the shift register drains
    @(negedge clk);
    check("R5", {6'b0, drv_en, rcv_en}, 8'h01);
    txf_nempty = 1'b1; #1;
    check("R10", {6'b0, drv_en, rcv_en}, 8'h01);
    @(negedge clk);
    check("R10", {6'b0, drv_en, rcv_en}, 8'h02);
    txf_nempty = 1'b0; tsr_busy = 1'b1;
    @(negedge clk);
    check("R5", {6'b0, drv_en, rcv_en}, 8'h02);
    @(negedge clk);
    check("R5", {6'b0, drv_en, rcv_en}, 8'h02);
    tsr_busy = 1'b0;
    @(negedge clk);
    check("R5", {6'b0, drv_en, rcv_en}, 8'h01);

    // R6 master enable cleared while transmitting in auto mode
    txf_nempty = 1'b1;
    wr_reg(4'hF, 8'h03);
    @(negedge clk);
    check("R6", {6'b0, drv_en, rcv_en}, 8'h00);

    // R1 reset again restores control byte
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_check("R1", 4'hF, 8'h03);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule